// File: doc/BRIEF.md
# Fractional Master Clock Divider

This block derives an audio master clock from a faster source clock at a rational ratio. The output frequency is the source frequency times fract / divide. Each source cycle, an accumulator grows by twice the fract value. Whenever the sum reaches divide, divide is taken off and the output toggles. Over a long window this gives fract / divide of the source rate.

Software writes the two ratio values through a small write port, one value per transaction, each encoded as its value minus one. A write sets a busy flag. The new ratio is loaded only at an output edge, so that no short pulse appears, and the busy flag clears in that same cycle. The expected sequence is to write divide, wait for busy to drop, then write fract and wait again. An enable input chooses between two modes. In one, the generated clock is driven out and the pad driver is enabled. In the other, the generator is held in reset with its output low, and the pad is left to an external source.

Top module: `mclk_frac_div`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `mclk_o`, `mclk_oe` and `busy` are 0.
- R2: A write with `cfg_sel`=0 sets the pending divide and with `cfg_sel`=1 the pending fract; in both cases the stored value is `cfg_wdata`+1.
- R3: Once a ratio (d, f) is loaded, the number of `mclk_o` transitions in the N source cycles that follow the load edge is exactly floor(2·f·N/d).
- R4: `busy` reads 1 in the cycle after any write and stays 1 until the pending ratio is loaded.
- R5: While enabled, `busy` falls only in a cycle where `mclk_o` also changes, because the ratio is loaded at an output edge.
- R6: If 2·f exceeds d, the effective fract is floor(d/2), so the output never exceeds half the source rate. With d=1, the effective fract is 0 and the output stays still.
- R7: With `out_en`=0, `mclk_o` is 0 from the next cycle on, the accumulator is held at zero, and a pending ratio is loaded on the next edge without waiting for an output edge.
- R8: `mclk_oe` equals `out_en` delayed by one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Source clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Ratio write strobe, one cycle per value |
| cfg_sel | input | 1 | 0 selects divide, 1 selects fract |
| cfg_wdata | input | W | Ratio value minus one |
| out_en | input | 1 | 1 generates and drives the clock, 0 holds the generator off |
| busy | output | 1 | A written ratio is not yet in effect |
| mclk_o | output | 1 | Generated master clock |
| mclk_oe | output | 1 | Pad driver enable for the master clock |

## Verification
The assertions assume that software follows the handshake. In that flow, a ratio that leaves the effective fract at 0 (divide of 1) is loaded only while the generator is disabled, because otherwise no output edge ever comes and `busy` never clears. The stimulus keeps to this: it applies divide 1 only with `out_en` low, and it waits for `busy` to drop after every write before it writes again. Edge counts are taken only over windows that start at a known load edge, where the accumulator is zero.

// File: rtl/mclk_div_pkg.sv
package mclk_div_pkg;
  typedef enum logic {
    SEL_DIVIDE = 1'b0,
    SEL_FRACT  = 1'b1
  } ratio_sel_e;
endpackage

// File: rtl/mclk_ratio_regs.sv
module mclk_ratio_regs
  import mclk_div_pkg::*;
#(
  parameter int unsigned W = 8,
  parameter logic [W-1:0] RST_DIV_ENC = 1,
  parameter logic [W-1:0] RST_FRC_ENC = 0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_en,
  input  logic         wr_sel,
  input  logic [W-1:0] wr_data,
  input  logic         load,
  output logic [W:0]   div_q,
  output logic [W:0]   frc_q,
  output logic         busy
);
  localparam int unsigned VW = W + 1;
  localparam logic [VW-1:0] RST_DIV_FULL = {1'b0, RST_DIV_ENC} + 1'b1;
  localparam logic [VW-1:0] RST_FRC_FULL = {1'b0, RST_FRC_ENC} + 1'b1;
  localparam logic [VW-1:0] RST_FRC_EFF =
    ({RST_FRC_FULL, 1'b0} > {1'b0, RST_DIV_FULL}) ? (RST_DIV_FULL >> 1) : RST_FRC_FULL;

  logic [W-1:0]  pnd_div, pnd_frc;
  logic [VW-1:0] div_full, frc_full, frc_eff;

  // decode minus-one encoding and clamp fract to at most half of divide
  always_comb begin
    div_full = {1'b0, pnd_div} + 1'b1;
    frc_full = {1'b0, pnd_frc} + 1'b1;
    if ({frc_full, 1'b0} > {1'b0, div_full}) frc_eff = div_full >> 1;
    else                                     frc_eff = frc_full;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pnd_div <= RST_DIV_ENC;
      pnd_frc <= RST_FRC_ENC;
      div_q   <= RST_DIV_FULL;
      frc_q   <= RST_FRC_EFF;
      busy    <= 1'b0;
    end else begin
      if (wr_en) begin
        if (ratio_sel_e'(wr_sel) == SEL_FRACT) pnd_frc <= wr_data;
        else                                   pnd_div <= wr_data;
      end
      if (load) begin
        div_q <= div_full;
        frc_q <= frc_eff;
      end
      if (wr_en)     busy <= 1'b1;
      else if (load) busy <= 1'b0;
    end
  end
endmodule

// File: rtl/mclk_accum.sv
module mclk_accum #(
  parameter int unsigned W = 8
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       en,
  input  logic [W:0] div_q,
  input  logic [W:0] frc_q,
  input  logic       load,
  output logic       hit,
  output logic       mclk
);
  localparam int unsigned AW = W + 3;

  logic [AW-1:0] acc, sum, div_ext;

  always_comb begin
    div_ext = {2'b00, div_q};
    sum     = acc + {1'b0, frc_q, 1'b0};
    hit     = en && (sum >= div_ext);
  end

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      acc  <= '0;
      mclk <= 1'b0;
    end else begin
      if (hit)       mclk <= ~mclk;
      if (load)      acc  <= '0;
      else if (hit)  acc  <= sum - div_ext;
      else           acc  <= sum;
    end
  end
endmodule

// File: rtl/mclk_frac_div.sv
module mclk_frac_div #(
  parameter int unsigned W = 8,
  parameter logic [W-1:0] RST_DIV_ENC = 1,
  parameter logic [W-1:0] RST_FRC_ENC = 0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         cfg_wr,
  input  logic         cfg_sel,
  input  logic [W-1:0] cfg_wdata,
  input  logic         out_en,
  output logic         busy,
  output logic         mclk_o,
  output logic         mclk_oe
);
  logic [W:0] div_act, frc_act;
  logic       hit, load;

  // apply pending ratio at an output edge, or at once while disabled
  assign load = busy && (!out_en || hit);

  mclk_ratio_regs #(
    .W(W), .RST_DIV_ENC(RST_DIV_ENC), .RST_FRC_ENC(RST_FRC_ENC)
  ) u_regs (
    .clk(clk), .rst(rst), .wr_en(cfg_wr), .wr_sel(cfg_sel), .wr_data(cfg_wdata),
    .load(load), .div_q(div_act), .frc_q(frc_act), .busy(busy)
  );

  mclk_accum #(.W(W)) u_acc (
    .clk(clk), .rst(rst), .en(out_en), .div_q(div_act), .frc_q(frc_act),
    .load(load), .hit(hit), .mclk(mclk_o)
  );

  always_ff @(posedge clk) begin
    if (rst) mclk_oe <= 1'b0;
    else     mclk_oe <= out_en;
  end
endmodule

// File: rtl/mclk_frac_div_chk.sv
module mclk_frac_div_chk #(
  parameter int unsigned W = 8
) (
  input logic       clk,
  input logic       rst,
  input logic       cfg_wr,
  input logic       out_en,
  input logic       busy,
  input logic       mclk_o,
  input logic       mclk_oe,
  input logic [W:0] div_act,
  input logic [W:0] frc_act
);
  p_busy_set_r4: assert property (@(posedge clk) disable iff (rst)
    cfg_wr |=> busy);

  p_load_at_edge_r5: assert property (@(posedge clk) disable iff (rst)
    ($fell(busy) && $past(out_en)) |-> (mclk_o != $past(mclk_o)));

  p_half_rate_r6: assert property (@(posedge clk) disable iff (rst)
    {frc_act, 1'b0} <= {1'b0, div_act});

  p_low_when_off_r7: assert property (@(posedge clk) disable iff (rst)
    !out_en |=> !mclk_o);

  p_oe_follows_r8: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (mclk_oe == $past(out_en)));

  p_reset_quiet_r1: assert property (@(posedge clk)
    rst |=> (!busy && !mclk_o && !mclk_oe));
endmodule

bind mclk_frac_div mclk_frac_div_chk #(.W(W)) u_chk (
  .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .out_en(out_en), .busy(busy),
  .mclk_o(mclk_o), .mclk_oe(mclk_oe), .div_act(div_act), .frc_act(frc_act)
);

// File: tb/sim_mclk_frac_div.sv
module sim_mclk_frac_div;
  localparam int W = 8;
  localparam int NV = 7;
  localparam int WIN = 200;
  // stimulus: encoded divide, encoded fract; expected count derived below
  localparam logic [W-1:0] V_DIV [NV] = '{8'd1, 8'd9, 8'd99, 8'd255, 8'd6, 8'd12, 8'd2};
  localparam logic [W-1:0] V_FRC [NV] = '{8'd0, 8'd2, 8'd6,  8'd0,   8'd4, 8'd12, 8'd0};

  logic clk = 1'b0, rst = 1'b1, cfg_wr = 1'b0, cfg_sel = 1'b0, out_en = 1'b0;
  logic [W-1:0] cfg_wdata = '0;
  logic busy, mclk_o, mclk_oe;
  int n_chk = 0, n_bad = 0;

  always #10 clk = ~clk;

  mclk_frac_div #(.W(W)) u0 (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .out_en(out_en), .busy(busy), .mclk_o(mclk_o), .mclk_oe(mclk_oe)
  );

  // R6 clamp and R3 count, from the requirement text
  function automatic int expect_edges(int denc, int fenc, int n);
    int d = denc + 1;
    int f = fenc + 1;
    if (2 * f > d) f = d / 2;
    return (2 * f * n) / d;
  endfunction

  task automatic check(string tag, int got, int exp);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic cfg_write(logic sel, logic [W-1:0] val);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_sel = sel; cfg_wdata = val;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic wait_idle();
    logic prev = mclk_o;
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (!busy) begin
        if (out_en) check("R5 edge at load", int'(mclk_o != prev), 1);
        return;
      end
      prev = mclk_o;
    end
    check("R4 busy never cleared", 1, 0);
  endtask

  task automatic count_edges(int n, output int cnt);
    logic prev = mclk_o;
    cnt = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (mclk_o != prev) cnt++;
      prev = mclk_o;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got %0d expected %0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    int cnt;
    repeat (3) @(negedge clk);
    check("R1 mclk_o in reset", int'(mclk_o), 0);
    check("R1 mclk_oe in reset", int'(mclk_oe), 0);
    check("R1 busy in reset", int'(busy), 0);
    rst = 1'b0;
    out_en = 1'b1;
    @(negedge clk);
    check("R8 oe follows enable", int'(mclk_oe), 1);

    // table walk: R2 encoding, R3 rate, R6 clamp for the last entries
    for (int v = 0; v < NV; v++) begin
      cfg_write(1'b0, V_DIV[v]);
      check("R4 busy after divide write", int'(busy), 1);
      wait_idle();
      cfg_write(1'b1, V_FRC[v]);
      wait_idle();
      count_edges(WIN, cnt);
      check($sformatf("R2/R3/R6 vector %0d", v), cnt,
            expect_edges(int'(V_DIV[v]), int'(V_FRC[v]), WIN));
    end

    // R4: busy set by a fract write
    cfg_write(1'b1, 8'd0);
    check("R4 busy after fract write", int'(busy), 1);
    wait_idle();

    // R7/R8: disable, load without an output edge, restart from zero
    @(negedge clk); out_en = 1'b0;
    @(negedge clk);
    check("R7 output low when off", int'(mclk_o), 0);
    check("R8 oe drops", int'(mclk_oe), 0);
    cfg_write(1'b0, 8'd3);
    check("R4 busy while off", int'(busy), 1);
    @(negedge clk);
    check("R7 immediate load when off", int'(busy), 0);
    out_en = 1'b1;
    count_edges(40, cnt);
    check("R7 restart from cleared accumulator", cnt, expect_edges(3, 0, 40));

    // R6 boundary: divide 1 leaves effective fract 0, output still
    @(negedge clk); out_en = 1'b0;
    cfg_write(1'b0, 8'd0);
    @(negedge clk);
    check("R6 load of divide 1", int'(busy), 0);
    out_en = 1'b1;
    count_edges(50, cnt);
    check("R6 no edges at divide 1", cnt, 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule